// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block gathers up to 64 interrupt source lines into one interrupt request to a processor. The sources form banks of 32. Every line first passes through a two-stage synchroniser. Software works through a small 32-bit register bus with a 64-byte window. Each bank shows software four word registers: latched events, the enable mask, a write-one-to-clear acknowledge, and the live synchronised line level. In each word, bit n belongs to source n of that bank.

The sources come in two kinds, set by a fixed level-type mask given per bank as a parameter. Edge sources latch an event on a rising edge of their line, and only while they are enabled. Level sources never latch. They request for as long as their line is high and they are enabled. Software finds them through the level register. Turning on an enable bit while the line is already high does not create an event, so software must check the level register after it unmasks a source. The request output is a plain combinational OR over all enabled pending sources.

Top module: `irq_bank_ctrl`

## Requirements
- R1: While reset is low, and after it is released, every enable bit and every event bit is zero, and `irq_out` is low.
- R2: The bank for sources 0–31 decodes at byte offsets 0x20–0x2F. The bank for sources 32–63 decodes at 0x10–0x1F. Inside a bank, the event register is at +0x0, enable at +0x4, acknowledge at +0x8 and level at +0xC. Bit n of each word is source n of the bank.
- R3: A write to an enable register takes effect at the next clock edge. A read of that register then returns exactly the value written.
- R4: An edge source's event bit becomes 1 when its input rises while its enable bit is 1. The bit reads as 1 after the third rising clock edge that samples the new high level.
- R5: A rising edge on a source that is disabled latches nothing. Enabling a source whose input is already high does not set its event bit.
- R6: Writing 1 to an acknowledge bit clears the matching event bit at the next edge. Acknowledge bits written as 0 change nothing. The acknowledge register always reads as zero.
- R7: If an event is set and acknowledged in the same cycle, the event bit stays 1.
- R8: The level register returns the synchronised input two clock edges after the input changes, whatever the enable mask holds.
- R9: A level-type source never latches an event. It requests while its synchronised line is high and its enable bit is 1. By default, sources 20–28 of the low bank are level-type (0x1ff00000), and the high bank has none.
- R10: `irq_out` is 1 exactly when (event OR (level AND level-type)) AND enable is non-zero in some bank.
- R11: A read at an offset outside both banks (0x00–0x0F, 0x30–0x3F) or at an address not word-aligned returns zero. A write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 64 | Interrupt source lines; bit 32·b+n is source n of bank b |
| bus_addr | input | 6 | Byte address inside the register window |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A stuck or stale event or enable bit shows up on `irq_out` in the same cycle it goes wrong, whenever the source is enabled. It shows up on `bus_rdata` as soon as the bench points the address at that register. A synchroniser stage too many or too few moves the level readback and the event set by one edge, and a per-cycle comparison catches that at once. The dangerous cases are the coincident set and acknowledge, and enabling a source while its line is high. Each of these leaves a difference that stays in the event register until the next acknowledge, so it cannot slip past unseen.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 6;

    // Word select inside one bank (byte offset bits [3:2])
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    // Bank b sits 16 bytes below bank b-1, starting at 0x20
    function automatic logic [ADDR_W-1:0] bank_base(input int idx);
        return ADDR_W'(32 - 16 * idx);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int           W          = 32,
    parameter logic [W-1:0] LEVEL_TYPE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_sync,
    input  logic         en_wr,
    input  logic [W-1:0] en_data,
    input  logic         ack_wr,
    input  logic [W-1:0] ack_data,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] en_o,
    output logic         pending_o
);

    typedef struct packed {
        logic [W-1:0] evt;
        logic [W-1:0] en;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t     st_d, st_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr;

    always_comb begin
        st_d      = st_q;
        rise      = line_sync & ~st_q.prev;
        clr       = ack_wr ? ack_data : '0;
        st_d.prev = line_sync;
        // acknowledge first, then new edges: a coincident set survives
        st_d.evt  = (st_q.evt & ~clr) | (rise & st_q.en & ~LEVEL_TYPE);
        if (en_wr) st_d.en = en_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o     = st_q.evt;
    assign en_o      = st_q.en;
    assign pending_o = |((st_q.evt | (line_sync & LEVEL_TYPE)) & st_q.en);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int                  NUM_BANKS   = 2,
    parameter logic [2*WORD_W-1:0] LEVEL_TYPES = 64'h0000_0000_1ff0_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*WORD_W-1:0] src_in,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic                        irq_out
);

    localparam int SRC_W = NUM_BANKS * WORD_W;

    logic [SRC_W-1:0]     ev_all;
    logic [SRC_W-1:0]     en_all;
    logic [SRC_W-1:0]     lvl_all;
    logic [NUM_BANKS-1:0] hit_v;
    logic [NUM_BANKS-1:0] pend_v;
    reg_sel_e             sel;

    assign sel = reg_sel_e'(bus_addr[3:2]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = bank_base(b);

        assign hit_v[b] = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4])
                        && (bus_addr[1:0] == 2'b00);

        irq_sync #(.W(WORD_W)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (src_in[b*WORD_W +: WORD_W]),
            .sync_o  (lvl_all[b*WORD_W +: WORD_W])
        );

        irq_bank #(
            .W          (WORD_W),
            .LEVEL_TYPE (LEVEL_TYPES[b*WORD_W +: WORD_W])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_sync (lvl_all[b*WORD_W +: WORD_W]),
            .en_wr     (bus_wr && hit_v[b] && (sel == REG_ENABLE)),
            .en_data   (bus_wdata),
            .ack_wr    (bus_wr && hit_v[b] && (sel == REG_ACK)),
            .ack_data  (bus_wdata),
            .evt_o     (ev_all[b*WORD_W +: WORD_W]),
            .en_o      (en_all[b*WORD_W +: WORD_W]),
            .pending_o (pend_v[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_v[b]) begin
                case (sel)
                    REG_EVENT:  bus_rdata = ev_all[b*WORD_W +: WORD_W];
                    REG_ENABLE: bus_rdata = en_all[b*WORD_W +: WORD_W];
                    REG_LEVEL:  bus_rdata = lvl_all[b*WORD_W +: WORD_W];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq_out = |pend_v;

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int                  NUM_BANKS   = 2,
    parameter logic [2*WORD_W-1:0] LEVEL_TYPES = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic [WORD_W-1:0]           bus_wdata,
    input logic [WORD_W-1:0]           bus_rdata,
    input logic                        irq_out,
    input logic [NUM_BANKS*WORD_W-1:0] ev_all,
    input logic [NUM_BANKS*WORD_W-1:0] en_all,
    input logic [NUM_BANKS*WORD_W-1:0] lvl_all
);

    localparam int SRC_W = NUM_BANKS * WORD_W;
    localparam logic [SRC_W-1:0] LVL_T = LEVEL_TYPES[SRC_W-1:0];
    localparam logic [ADDR_W-1:0] EN0_ADDR = bank_base(0) + ADDR_W'(4);

    logic unmapped;
    assign unmapped = (bus_addr[1:0] != 2'b00)
                   || (bus_addr[5:4] == 2'b00) || (bus_addr[5:4] == 2'b11);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_all == '0 && ev_all == '0 && !irq_out));

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EN0_ADDR) |=> (en_all[WORD_W-1:0] == $past(bus_wdata)));

    assert_event_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_all & ~$past(ev_all) & ~$past(en_all)) == '0));

    assert_ack_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:2] == 2'd2) |-> (bus_rdata == '0));

    assert_level_requests_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_all & LVL_T & en_all) != '0) |-> irq_out);

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> !irq_out);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));

endmodule

bind irq_bank_ctrl irq_bank_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .LEVEL_TYPES (LEVEL_TYPES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .ev_all    (ev_all),
    .en_all    (en_all),
    .lvl_all   (lvl_all)
);

// File: tb/tb_irq_bank_ctrl.sv
module tb_irq_bank_ctrl;

    localparam logic [63:0] LVL = 64'h0000_0000_1ff0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    irq_bank_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // ---------------- behavioural reference ----------------
    logic [63:0] m_ev, m_en;
    logic [63:0] hist[$];   // [0]=two edges ago, [1]=synchronised level, [2]=latest sample

    function automatic int decode_bank(input logic [5:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a[5:4] == 2'b10) return 0;
        if (a[5:4] == 2'b01) return 1;
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ev = '0;
            m_en = '0;
            hist = '{64'd0, 64'd0, 64'd0};
        end else begin
            automatic logic [63:0] rise = hist[1] & ~hist[0];
            automatic logic [63:0] clr  = '0;
            automatic logic [63:0] en_o = m_en;
            automatic int b = decode_bank(bus_addr);
            if (bus_wr && b >= 0) begin
                if (bus_addr[3:2] == 2'd1) m_en[b*32 +: 32] = bus_wdata;
                if (bus_addr[3:2] == 2'd2) clr[b*32 +: 32]  = bus_wdata;
            end
            m_ev = (m_ev & ~clr) | (rise & en_o & ~LVL);
            hist.push_back(src_in);
            void'(hist.pop_front());
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [5:0] a);
        automatic int b = decode_bank(a);
        if (b < 0) return '0;
        case (a[3:2])
            2'd0:    return m_ev[b*32 +: 32];
            2'd1:    return m_en[b*32 +: 32];
            2'd3:    return hist[1][b*32 +: 32];
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |((m_ev | (hist[1] & LVL)) & m_en);
    endfunction

    // one cycle: drive bus, compare the outputs, pass a rising edge
    task automatic cyc(input logic [5:0] a, input logic w, input logic [31:0] d);
        bus_addr  = a;
        bus_wr    = w;
        bus_wdata = d;
        #1;
        n_cmp++;
        if (bus_rdata !== exp_rdata(a) || irq_out !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s addr=%h rdata act=%h exp=%h irq act=%b exp=%b",
                     cur_req, a, bus_rdata, exp_rdata(a), irq_out, exp_irq());
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input int n);
        for (int i = 0; i < n; i++) cyc(a, 1'b0, '0);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state, enables/events read zero, no request
        cur_req = "R1";
        rd(6'h24, 2); rd(6'h14, 1); rd(6'h20, 1);
        rst_n = 1'b1;
        rd(6'h24, 1); rd(6'h20, 1);

        // R3 / R2: enable write and readback in both banks
        cur_req = "R3";
        cyc(6'h24, 1'b1, 32'h0000_00FF);
        rd(6'h24, 1);
        cur_req = "R2";
        cyc(6'h14, 1'b1, 32'h0010_0001);
        rd(6'h14, 1); rd(6'h24, 1);

        // R4: rising edge on enabled source 0 latches, third edge visible
        cur_req = "R4";
        src_in[0] = 1'b1;
        rd(6'h20, 5);
        cur_req = "R10";
        rd(6'h20, 1);

        // R6: ack written as zero has no effect, ack reads zero, ack 1 clears
        cur_req = "R6";
        cyc(6'h28, 1'b1, 32'h0);
        rd(6'h20, 1); rd(6'h28, 1);
        cyc(6'h28, 1'b1, 32'h1);
        rd(6'h20, 2);

        // R5: edge on disabled source 8, then enable it while high
        cur_req = "R5";
        src_in[8] = 1'b1;
        rd(6'h20, 5);
        cyc(6'h24, 1'b1, 32'h0000_01FF);
        rd(6'h20, 4);

        // R7: set and acknowledge in the same cycle, set wins
        cur_req = "R7";
        src_in[1] = 1'b1;
        for (int i = 0; i < 4; i++) cyc(6'h28, 1'b1, 32'h2);
        rd(6'h20, 2);

        // R8: level readback independent of enable (source 25 disabled)
        cur_req = "R8";
        src_in[25] = 1'b1;
        rd(6'h2C, 4);
        src_in[25] = 1'b0;
        rd(6'h2C, 3);

        // R9: level-type source 20 requests while high and enabled, never latches
        cur_req = "R9";
        src_in[20] = 1'b1;
        rd(6'h20, 3);
        cyc(6'h24, 1'b1, 32'h0010_0000);
        rd(6'h20, 3);
        src_in[20] = 1'b0;
        rd(6'h20, 4);
        // bank1 source 20 is edge-type by default
        src_in[52] = 1'b1;
        rd(6'h10, 4);
        cyc(6'h18, 1'b1, 32'h0010_0000);
        rd(6'h10, 2);

        // R11: unmapped and misaligned accesses
        cur_req = "R11";
        cyc(6'h04, 1'b1, 32'hFFFF_FFFF);
        cyc(6'h34, 1'b1, 32'hFFFF_FFFF);
        cyc(6'h25, 1'b1, 32'hFFFF_FFFF);
        rd(6'h24, 1); rd(6'h14, 1);
        rd(6'h00, 1); rd(6'h3C, 1); rd(6'h2E, 1);

        // mixed stress over all requirements R2 R4 R5 R6 R7 R8 R9 R10
        cur_req = "R10";
        for (int i = 0; i < 4000; i++) begin
            automatic logic [5:0] a = 6'((($urandom % 16) * 4) + (($urandom % 8) == 0 ? 1 : 0));
            automatic logic w = (($urandom % 4) == 0);
            automatic logic [31:0] d = $urandom;
            src_in = src_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            cyc(a, w, d);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired in %s act=hung exp=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule